// File: doc/BRIEF.md
# HDLC Transmit Frame Terminator

This block turns a stream of bytes from a transmit FIFO into a bit-serial HDLC line stream, one line bit per clock. Bytes go out least significant bit first. A zero is stuffed after every run of five ones in data and checksum. When no frame is in progress the line carries continuous flags (`01111110`). A frame starts as soon as the FIFO offers a byte at the end of a flag or abort. The first bit of the frame follows the last bit of that flag directly.

There are two ways to end a frame cleanly. The FIFO can mark a byte with its end tag, or a loadable character counter can mark the Nth byte it pops. After that byte the block sends the inverted checksum, when enabled, and then a closing flag. That flag is also the opening flag of the next frame whenever data is already waiting. If the FIFO runs dry before an end-marked byte, a two-bit mode picks the recovery: a short abort, a long abort, a bare closing flag, or checksum then flag. An optional hold stops further pops after an end-marked byte until a release pulse arrives. Three single-cycle pulses report when the end byte, the checksum and the closing flag have finished on the line.

Top module: `hdlc_tx_frame_term`

## Requirements
- R1: While reset is low `txBit` is 1 and `fifoPop`, `eofSent`, `crcSent` and `allSent` are 0. After reset, with an empty FIFO, the line carries back-to-back flags and no abort.
- R2: Data bytes leave least significant bit first. A 0 is inserted after five consecutive 1s in data and checksum bits. Flags (`01111110`) and aborts are sent without insertion.
- R3: A byte popped with `fifoEof`=1 ends the frame. With `crcAtEnd`=1 it is followed by the checksum and then a flag. The checksum is CRC-16 with reflected polynomial 0x8408, register preset to all ones, computed over the data bits in line order, inverted, and sent low byte first, LSB first.
- R4: With `crcAtEnd`=0, the end-marked byte is followed directly by the closing flag and no checksum.
- R5: If the FIFO is empty at the end of a data byte that is not end-marked, `underrunMode`=0 sends 7 ones and `underrunMode`=1 sends 15 ones. Flags follow, and no completion pulse is given.
- R6: On the same underrun, `underrunMode`=2 closes the frame with a flag and no checksum. `underrunMode`=3 sends the checksum and then a flag.
- R7: A `cntLoad` pulse with `cntValue`=N>0 makes the Nth byte popped afterwards count as end-marked, whatever its `fifoEof`. The counter is then inactive.
- R8: If `fifoValid` is 1 when a closing flag's last bit is decided, the next frame begins right after that single flag. Otherwise at least one further flag is sent first.
- R9: With `waitToSend`=1, once an end-marked byte is popped no further pop occurs until a `releaseHold` pulse, even while `fifoValid` is 1.
- R10: `eofSent`, `crcSent` and `allSent` are one cycle wide. Each is high in the cycle the last bit of the end-marked byte, the checksum, or the closing flag is on `txBit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one line bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| fifoValid | input | 1 | FIFO holds a byte |
| fifoData | input | DATA_W | Byte at the FIFO head |
| fifoEof | input | 1 | Head byte is end-marked |
| fifoPop | output | 1 | Take the head byte at this edge |
| underrunMode | input | 2 | 0 short abort, 1 long abort, 2 flag, 3 checksum+flag |
| crcAtEnd | input | 1 | Append checksum after an end-marked byte |
| waitToSend | input | 1 | Hold pops after an end-marked byte |
| releaseHold | input | 1 | Pulse clearing the hold |
| cntLoad | input | 1 | Pulse loading the character counter |
| cntValue | input | CNT_W | Byte count for the counter |
| txBit | output | 1 | Serial line bit |
| eofSent | output | 1 | End-marked byte finished |
| crcSent | output | 1 | Checksum finished |
| allSent | output | 1 | Closing flag finished |

## Verification
A line bit is registered, so whatever the control decides in a cycle reaches `txBit` one cycle later, together with the completion pulse for that unit. The bench samples on the falling edge. Its receiver decodes flags, stuffed zeros and aborts from `txBit` directly, and checks `allSent` at the very sample where it sees a closing flag end. The FIFO model records `fifoPop` at the falling edge and retires the byte just after the next rising edge, matching the design's single registered pop. Frame-level results are taken only after the decoded frame count is reached or a fixed idle window has passed.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [1:0] {U_FLAG, U_DATA, U_CRC, U_ABORT} unitKind_t;

  // strobes from control to datapath, all only on a unit boundary
  typedef struct packed {
    logic loadFlag;
    logic loadData;
    logic loadCrc;
    logic loadAbortShort;
    logic loadAbortLong;
    logic crcInit;
  } dpCtl_t;

  localparam logic [7:0] FLAG_PATTERN = 8'h7E;
endpackage

// File: rtl/hdlc_tx_dp.sv
module hdlc_tx_dp
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CRC_W       = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter int SHORT_ABORT = 7,
  parameter int LONG_ABORT  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] byteIn,
  output logic              unitDone,
  output logic              txBit
);
  localparam int SH_W  = (CRC_W > LONG_ABORT) ? ((CRC_W > DATA_W) ? CRC_W : DATA_W)
                                              : ((LONG_ABORT > DATA_W) ? LONG_ABORT : DATA_W);
  localparam int LEN_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]  sh;
  logic [LEN_W-1:0] bitsLeft;
  logic             stuffUnit;
  logic             crcUnit;
  logic [2:0]       ones;
  logic [CRC_W-1:0] crc;
  logic [CRC_W-1:0] crcNext;
  logic [CRC_W-1:0] crcNow;
  logic             needStuff;
  logic             curBit;

  assign needStuff = (ones == 3'd5);
  assign curBit    = sh[0];
  assign unitDone  = !needStuff && (bitsLeft == LEN_W'(1));

  always_comb begin
    crcNext = (crc >> 1) ^ (((crc[0] ^ curBit) == 1'b1) ? CRC_POLY : '0);
    crcNow  = (crcUnit && !needStuff) ? crcNext : crc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sh        <= SH_W'(FLAG_PATTERN);
      bitsLeft  <= LEN_W'(8);
      stuffUnit <= 1'b0;
      crcUnit   <= 1'b0;
      ones      <= '0;
      crc       <= '1;
      txBit     <= 1'b1;
    end else begin
      txBit <= needStuff ? 1'b0 : curBit;
      if (needStuff)               ones <= '0;
      else if (stuffUnit && curBit) ones <= ones + 3'd1;
      else                          ones <= '0;
      if (!needStuff) begin
        sh       <= sh >> 1;
        bitsLeft <= bitsLeft - LEN_W'(1);
      end
      if (ctl.crcInit) crc <= '1;
      else             crc <= crcNow;
      if (ctl.loadFlag) begin
        sh <= SH_W'(FLAG_PATTERN); bitsLeft <= LEN_W'(8);
        stuffUnit <= 1'b0; crcUnit <= 1'b0;
      end
      if (ctl.loadData) begin
        sh <= SH_W'(byteIn); bitsLeft <= LEN_W'(DATA_W);
        stuffUnit <= 1'b1; crcUnit <= 1'b1;
      end
      if (ctl.loadCrc) begin
        sh <= SH_W'(~crcNow); bitsLeft <= LEN_W'(CRC_W);
        stuffUnit <= 1'b1; crcUnit <= 1'b0;
      end
      if (ctl.loadAbortShort) begin
        sh <= '1; bitsLeft <= LEN_W'(SHORT_ABORT);
        stuffUnit <= 1'b0; crcUnit <= 1'b0;
      end
      if (ctl.loadAbortLong) begin
        sh <= '1; bitsLeft <= LEN_W'(LONG_ABORT);
        stuffUnit <= 1'b0; crcUnit <= 1'b0;
      end
    end
  end

  AST_STUFF_AFTER_FIVE: assert property (@(posedge clk) disable iff (!rstN)
    (ones == 3'd5) |=> (txBit == 1'b0)); // R2
  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    ones <= 3'd5); // R2
  AST_LOAD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadFlag || ctl.loadData || ctl.loadCrc || ctl.loadAbortShort || ctl.loadAbortLong)
      |-> unitDone); // R10
  AST_NEVER_DRY: assert property (@(posedge clk) disable iff (!rstN)
    bitsLeft != '0); // R8
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             unitDone,
  input  logic             fifoValid,
  input  logic             fifoEof,
  input  logic [1:0]       underrunMode,
  input  logic             crcAtEnd,
  input  logic             waitToSend,
  input  logic             releaseHold,
  input  logic             cntLoad,
  input  logic [CNT_W-1:0] cntValue,
  output dpCtl_t           ctl,
  output logic             fifoPop,
  output logic             eofSent,
  output logic             crcSent,
  output logic             allSent
);
  unitKind_t        kind;
  logic             curEof;
  logic             closing;
  logic             hold;
  logic [CNT_W-1:0] cnt;
  logic             cntActive;
  logic             avail;
  logic             tagEof;

  assign avail  = fifoValid && !hold;
  assign tagEof = fifoEof || (cntActive && cnt == CNT_W'(1));

  always_comb begin
    ctl = '0;
    if (unitDone) begin
      case (kind)
        U_DATA: begin
          if (curEof) begin
            if (crcAtEnd) ctl.loadCrc  = 1'b1;
            else          ctl.loadFlag = 1'b1;
          end else if (avail) begin
            ctl.loadData = 1'b1;
          end else begin
            case (underrunMode)
              2'd0:    ctl.loadAbortShort = 1'b1;
              2'd1:    ctl.loadAbortLong  = 1'b1;
              2'd2:    ctl.loadFlag       = 1'b1;
              default: ctl.loadCrc        = 1'b1;
            endcase
          end
        end
        U_CRC: ctl.loadFlag = 1'b1;
        default: begin
          if (avail) begin
            ctl.loadData = 1'b1;
            ctl.crcInit  = 1'b1;
          end else begin
            ctl.loadFlag = 1'b1;
          end
        end
      endcase
    end
  end

  assign fifoPop = ctl.loadData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kind      <= U_FLAG;
      curEof    <= 1'b0;
      closing   <= 1'b0;
      hold      <= 1'b0;
      cnt       <= '0;
      cntActive <= 1'b0;
      eofSent   <= 1'b0;
      crcSent   <= 1'b0;
      allSent   <= 1'b0;
    end else begin
      eofSent <= unitDone && kind == U_DATA && curEof;
      crcSent <= unitDone && kind == U_CRC;
      allSent <= unitDone && kind == U_FLAG && closing;
      if (unitDone) begin
        closing <= ctl.loadFlag && (kind == U_DATA || kind == U_CRC);
        if (ctl.loadData)                                kind <= U_DATA;
        else if (ctl.loadCrc)                            kind <= U_CRC;
        else if (ctl.loadFlag)                           kind <= U_FLAG;
        else                                             kind <= U_ABORT;
      end
      if (ctl.loadData) curEof <= tagEof;
      if (ctl.loadData && waitToSend && tagEof) hold <= 1'b1;
      else if (releaseHold)                     hold <= 1'b0;
      if (cntLoad) begin
        cnt       <= cntValue;
        cntActive <= (cntValue != '0);
      end else if (ctl.loadData && cntActive) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) cntActive <= 1'b0;
      end
    end
  end

  AST_HOLD_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    hold |-> !fifoPop); // R9
  AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> fifoValid); // R8
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eofSent, crcSent, allSent})); // R10
  AST_EOF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    eofSent |=> !eofSent); // R10
  AST_ALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    allSent |=> !allSent); // R10
  AST_COUNT_MARKS_END: assert property (@(posedge clk) disable iff (!rstN)
    (fifoPop && cntActive && cnt == CNT_W'(1) && !cntLoad) |=> (curEof && !cntActive)); // R7
endmodule

// File: rtl/hdlc_tx_frame_term.sv
module hdlc_tx_frame_term
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoValid,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoEof,
  output logic              fifoPop,
  input  logic [1:0]        underrunMode,
  input  logic              crcAtEnd,
  input  logic              waitToSend,
  input  logic              releaseHold,
  input  logic              cntLoad,
  input  logic [CNT_W-1:0]  cntValue,
  output logic              txBit,
  output logic              eofSent,
  output logic              crcSent,
  output logic              allSent
);
  dpCtl_t ctl;
  logic   unitDone;

  hdlc_tx_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .unitDone(unitDone),
    .fifoValid(fifoValid), .fifoEof(fifoEof),
    .underrunMode(underrunMode), .crcAtEnd(crcAtEnd),
    .waitToSend(waitToSend), .releaseHold(releaseHold),
    .cntLoad(cntLoad), .cntValue(cntValue),
    .ctl(ctl), .fifoPop(fifoPop),
    .eofSent(eofSent), .crcSent(crcSent), .allSent(allSent)
  );

  hdlc_tx_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteIn(fifoData),
    .unitDone(unitDone), .txBit(txBit)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> (txBit && !eofSent && !crcSent && !allSent)); // R1
endmodule

// File: tb/sim_hdlc_tx_frame_term.sv
`timescale 1ns/1ps
module sim_hdlc_tx_frame_term;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        fifoValid = 1'b0;
  logic [7:0]  fifoData = 8'h00;
  logic        fifoEof = 1'b0;
  logic        fifoPop;
  logic [1:0]  underrunMode = 2'd3;
  logic        crcAtEnd = 1'b1;
  logic        waitToSend = 1'b0;
  logic        releaseHold = 1'b0;
  logic        cntLoad = 1'b0;
  logic [15:0] cntValue = 16'd0;
  logic        txBit, eofSent, crcSent, allSent;

  hdlc_tx_frame_term u0 (
    .clk(clk), .rstN(rstN), .fifoValid(fifoValid), .fifoData(fifoData),
    .fifoEof(fifoEof), .fifoPop(fifoPop), .underrunMode(underrunMode),
    .crcAtEnd(crcAtEnd), .waitToSend(waitToSend), .releaseHold(releaseHold),
    .cntLoad(cntLoad), .cntValue(cntValue), .txBit(txBit),
    .eofSent(eofSent), .crcSent(crcSent), .allSent(allSent)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // FIFO model: pop observed mid-cycle, retired just after the edge
  logic [8:0] fq[$];
  logic [8:0] popped;
  bit popNow = 0;
  always @(negedge clk) popNow = fifoPop;
  always @(posedge clk) begin
    #1;
    if (popNow && fq.size() > 0) popped = fq.pop_front();
    popNow = 0;
    fifoValid = (fq.size() > 0);
    if (fq.size() > 0) {fifoEof, fifoData} = fq[0];
    else               {fifoEof, fifoData} = 9'h000;
  end

  // line receiver
  bit          bq[$];
  byte unsigned rxBytes[$];
  int          rxLens[$];
  int          rxGaps[$];
  bit          rxAllAt[$];
  int ones = 0, gap = 0, abortCnt = 0, abortRun = 0;
  int eofCnt = 0, crcCnt = 0, allCnt = 0, wideCnt = 0;
  bit synced = 0;
  bit prevE = 0, prevC = 0, prevA = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (eofSent) eofCnt++;
      if (crcSent) crcCnt++;
      if (allSent) allCnt++;
      if ((eofSent && prevE) || (crcSent && prevC) || (allSent && prevA)) wideCnt++;
      prevE = eofSent; prevC = crcSent; prevA = allSent;
      if (txBit) begin
        ones++;
        if (ones == 7) begin synced = 0; abortCnt++; end
        if (ones >= 7) abortRun = ones;
        else if (synced) bq.push_back(1'b1);
      end else begin
        if (ones == 6) begin
          if (synced) begin
            int n;
            n = bq.size() - 7;
            if (n == 0) gap++;
            else begin
              if (n % 8 == 0) begin
                rxLens.push_back(n / 8);
                for (int k = 0; k < n / 8; k++) begin
                  byte unsigned v;
                  v = 0;
                  for (int j = 0; j < 8; j++) if (bq[8*k+j]) v = v | byte'(1 << j);
                  rxBytes.push_back(v);
                end
              end else rxLens.push_back(-1);
              rxGaps.push_back(gap);
              rxAllAt.push_back(allSent);
              gap = 0;
            end
          end
          synced = 1;
          bq.delete();
        end else if (ones != 5 && ones < 7 && synced) begin
          bq.push_back(1'b0);
        end
        ones = 0;
      end
    end
  end

  // helpers
  byte unsigned expBytes[$];

  function automatic logic [15:0] fcsOf(input byte unsigned p[$]);
    logic [15:0] c;
    c = 16'hFFFF;
    foreach (p[i]) for (int j = 0; j < 8; j++) begin
      bit fb;
      fb = c[0] ^ p[i][j];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return ~c;
  endfunction

  task automatic addExp(input byte unsigned p[$], input bit withFcs);
    logic [15:0] f;
    f = fcsOf(p);
    foreach (p[i]) expBytes.push_back(p[i]);
    if (withFcs) begin
      expBytes.push_back(f[7:0]);
      expBytes.push_back(f[15:8]);
    end
  endtask

  task automatic clearRx();
    rxBytes.delete(); rxLens.delete(); rxGaps.delete(); rxAllAt.delete();
    expBytes.delete();
    eofCnt = 0; crcCnt = 0; allCnt = 0; abortCnt = 0; abortRun = 0; wideCnt = 0;
  endtask

  task automatic pushFrame(input byte unsigned p[$], input bit eofLast);
    foreach (p[i]) fq.push_back({(eofLast && i == p.size() - 1), p[i]});
  endtask

  task automatic waitFrames(input int n);
    for (int i = 0; i < 3000 && rxLens.size() < n; i++) @(negedge clk);
  endtask

  task automatic waitIdle(input int c);
    for (int i = 0; i < 3000 && fq.size() > 0; i++) @(negedge clk);
    repeat (c) @(negedge clk);
  endtask

  task automatic checkBytes(input string req);
    check(rxBytes.size() == expBytes.size(), req, "byte count", rxBytes.size(), expBytes.size());
    foreach (expBytes[i])
      if (i < rxBytes.size())
        check(rxBytes[i] == expBytes[i], req, $sformatf("byte %0d", i), rxBytes[i], expBytes[i]);
  endtask

  // scenarios
  task automatic testReset();
    repeat (3) @(negedge clk);
    check(txBit == 1'b1, "R1", "txBit in reset", txBit, 1);
    check(fifoPop == 1'b0, "R1", "fifoPop in reset", fifoPop, 0);
    check({eofSent, crcSent, allSent} == 3'b000, "R1", "pulses in reset",
          {eofSent, crcSent, allSent}, 0);
    rstN = 1'b1;
    repeat (40) @(negedge clk);
    check(synced == 1'b1, "R1", "idle flags seen", synced, 1);
    check(abortCnt == 0, "R1", "no abort at idle", abortCnt, 0);
  endtask

  task automatic testNormal();
    byte unsigned p[$] = '{8'h12, 8'h34, 8'h56};
    clearRx(); crcAtEnd = 1'b1;
    addExp(p, 1); pushFrame(p, 1);
    waitFrames(1); waitIdle(20);
    check(rxLens.size() == 1 && rxLens[0] == 5, "R3", "frame length",
          rxLens.size() > 0 ? rxLens[0] : -9, 5);
    checkBytes("R3");
    check(eofCnt == 1, "R10", "eofSent count", eofCnt, 1);
    check(crcCnt == 1, "R10", "crcSent count", crcCnt, 1);
    check(allCnt == 1, "R10", "allSent count", allCnt, 1);
    check(rxAllAt.size() == 1 && rxAllAt[0], "R10", "allSent on flag end",
          rxAllAt.size() > 0 ? int'(rxAllAt[0]) : 0, 1);
    check(wideCnt == 0, "R10", "pulse width", wideCnt, 0);
  endtask

  task automatic testStuffing();
    byte unsigned p[$] = '{8'hFF, 8'hFF, 8'h7E, 8'h1F, 8'hF8};
    clearRx(); crcAtEnd = 1'b1;
    addExp(p, 1); pushFrame(p, 1);
    waitFrames(1); waitIdle(20);
    checkBytes("R2");
    check(abortCnt == 0, "R2", "no seven-ones run in frame", abortCnt, 0);
  endtask

  task automatic testNoCrc();
    byte unsigned p[$] = '{8'hA5, 8'h3C};
    clearRx(); crcAtEnd = 1'b0;
    addExp(p, 0); pushFrame(p, 1);
    waitFrames(1); waitIdle(20);
    checkBytes("R4");
    check(crcCnt == 0, "R4", "no checksum pulse", crcCnt, 0);
    check(eofCnt == 1, "R4", "eofSent count", eofCnt, 1);
    crcAtEnd = 1'b1;
  endtask

  task automatic testAbort(input logic [1:0] mode, input int run);
    byte unsigned p[$] = '{8'h11, 8'h22};
    clearRx(); underrunMode = mode;
    pushFrame(p, 0);
    waitIdle(150);
    check(rxLens.size() == 0, "R5", "no frame delivered", rxLens.size(), 0);
    check(abortCnt == 1, "R5", "abort count", abortCnt, 1);
    check(abortRun == run, "R5", "abort run length", abortRun, run);
    check(allCnt == 0 && eofCnt == 0, "R5", "no completion pulse", allCnt + eofCnt, 0);
  endtask

  task automatic testUnderrunFlag();
    byte unsigned p[$] = '{8'h5A, 8'h0F};
    clearRx(); underrunMode = 2'd2;
    addExp(p, 0); pushFrame(p, 0);
    waitFrames(1); waitIdle(20);
    checkBytes("R6");
    check(crcCnt == 0 && allCnt == 1, "R6", "flag-only close pulses", crcCnt * 10 + allCnt, 1);
  endtask

  task automatic testUnderrunCrc();
    byte unsigned p[$] = '{8'h01, 8'h02, 8'h03};
    clearRx(); underrunMode = 2'd3;
    addExp(p, 1); pushFrame(p, 0);
    waitFrames(1); waitIdle(20);
    checkBytes("R6");
    check(crcCnt == 1 && eofCnt == 0, "R6", "checksum close pulses", crcCnt * 10 + eofCnt, 10);
  endtask

  task automatic testCounter();
    byte unsigned a[$] = '{8'hC1, 8'hC2, 8'hC3};
    byte unsigned b[$] = '{8'hC4, 8'hC5};
    clearRx(); underrunMode = 2'd3; crcAtEnd = 1'b1;
    cntValue = 16'd3; cntLoad = 1'b1;
    @(negedge clk); cntLoad = 1'b0;
    addExp(a, 1); addExp(b, 1);
    pushFrame(a, 0); pushFrame(b, 0);
    waitFrames(2); waitIdle(20);
    check(rxLens.size() == 2 && rxLens[0] == 5 && rxLens[1] == 4, "R7", "frame split",
          rxLens.size() > 0 ? rxLens[0] : -9, 5);
    checkBytes("R7");
    check(eofCnt == 1, "R7", "counter end pulse", eofCnt, 1);
    check(rxGaps.size() == 2 && rxGaps[1] == 0, "R8", "shared flag after counted end",
          rxGaps.size() > 1 ? rxGaps[1] : -9, 0);
  endtask

  task automatic testSharedFlag();
    byte unsigned f1[$] = '{8'h81};
    byte unsigned f2[$] = '{8'h42, 8'h99};
    byte unsigned f3[$] = '{8'h77};
    clearRx(); crcAtEnd = 1'b1;
    addExp(f1, 1); addExp(f2, 1);
    pushFrame(f1, 1); pushFrame(f2, 1);
    waitFrames(2);
    check(rxGaps.size() == 2 && rxGaps[1] == 0, "R8", "single flag when data waits",
          rxGaps.size() > 1 ? rxGaps[1] : -9, 0);
    repeat (40) @(negedge clk);
    addExp(f3, 1); pushFrame(f3, 1);
    waitFrames(3); waitIdle(20);
    check(rxGaps.size() == 3 && rxGaps[2] >= 1, "R8", "extra flags when FIFO empty",
          rxGaps.size() > 2 ? rxGaps[2] : -9, 1);
    checkBytes("R8");
  endtask

  task automatic testHold();
    byte unsigned f1[$] = '{8'h33};
    byte unsigned f2[$] = '{8'h44};
    clearRx(); waitToSend = 1'b1;
    addExp(f1, 1); addExp(f2, 1);
    pushFrame(f1, 1); pushFrame(f2, 1);
    waitFrames(1);
    repeat (200) @(negedge clk);
    check(rxLens.size() == 1, "R9", "second frame held", rxLens.size(), 1);
    check(fq.size() == 1, "R9", "no pop while held", fq.size(), 1);
    releaseHold = 1'b1; @(negedge clk); releaseHold = 1'b0;
    waitFrames(2); waitIdle(20);
    check(rxLens.size() == 2, "R9", "released frame sent", rxLens.size(), 2);
    checkBytes("R9");
    waitToSend = 1'b0;
    releaseHold = 1'b1; @(negedge clk); releaseHold = 1'b0;
  endtask

  initial begin
    testReset();
    testNormal();
    testStuffing();
    testNoCrc();
    testAbort(2'd0, 7);
    testAbort(2'd1, 15);
    testUnderrunFlag();
    testUnderrunCrc();
    testCounter();
    testSharedFlag();
    testHold();
    finishRun();
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end
endmodule